// File: doc/BRIEF.md
# Serial Host Command Port

This block receives settings from a microcontroller over three plain wires: a data line, a shift clock and a latch strobe. Each command is 7 to 26 bits long and is shifted in least significant bit first. When the latch strobe rises, the collected bits form one command. The last bit shifted in always occupies the top position of a 26-bit frame. A short prefix in the upper frame bits picks one of five targets:

- pitch-shift key code
- operating-mode word
- DSP-function word
- output attenuator level
- write to a 128-word coefficient memory

Decoded values are first held in shadow registers. They move to the outputs only when the processing core pulses `period_start`, which marks the start of each sample period, so the core never sees a setting change in the middle of a period.

Coefficient-memory writes leave the block on a valid/ready stream. A write waits in a one-entry slot until the next `period_start`. It is then presented with `cram_valid` high, and address and data stay frozen until the consumer raises `cram_ready`. The stream therefore carries at most one word per sample period. A new memory command that arrives while the slot is still occupied is dropped and sets a sticky overrun flag.

The shift clock, latch and data lines are brought into the system clock domain through synchronisers, and their edges are detected there.

Top module: `host_cmd_port`

## Requirements
- R1: Bits are taken LSB first on each rising shift clock. The last bit before the latch lands in frame bit 25, and earlier bits land in successively lower positions. Bits shifted beyond 26 fall off the bottom and have no effect.
- R2: If fewer than 7 bits were shifted since the previous latch, the latch is ignored and no register or write changes.
- R3: A frame with bits 25..23 = 000 is a key command with a 4-bit code in bits 22..19. `key_code` shows the code, and `key_cents` shows its signed pitch shift:
  - codes 0001..0110 give +100..+600 in steps of 100
  - code 0111 gives +1200
  - codes 0000 and 1000 give 0
  - codes 1001..1110 give -100..-600
  - code 1111 gives -1200
- R4: A frame with bits 25..24 = 01 sets the 14-bit attenuator level from bits 23..10.
- R5: A frame with bits 25..22 = 0010 sets the 12-bit mode word from bits 21..10.
- R6: A frame with bits 25..22 = 0011 sets the 12-bit function word from bits 21..10.
- R7: A decoded setting reaches its output only on the clock edge that samples `period_start` high. Until then the output keeps its previous value.
- R8: A frame with bit 25 = 1 is a memory write, with address in bits 24..18 and data in bits 17..0.
  - It is presented on the next `period_start`: `cram_valid` rises on the edge that samples that pulse.
  - `cram_valid`, `cram_addr` and `cram_data` hold steady while `cram_ready` is low.
  - `cram_valid` drops on the edge after the handshake completes.
- R9: At most one write is presented per sample period. A memory command that arrives while an earlier one is still waiting for `period_start` is dropped and sets `cram_overrun`, which stays high until reset.
- R10: While `rst_n` is low, the outputs take these values:
  - mode word, function word and key code are 0
  - attenuator level is 3FFF hex
  - `cram_valid` and `cram_overrun` are 0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_data | input | 1 | Serial command data, asynchronous |
| ser_clk | input | 1 | Serial shift clock, data taken on rising edge |
| ser_latch | input | 1 | Latch strobe, rising edge ends a command |
| period_start | input | 1 | One-cycle pulse at the start of each sample period |
| key_code | output | 4 | Active key code |
| key_cents | output | 12 | Signed pitch shift in cents |
| att_level | output | 14 | Active attenuator level |
| mode_cfg | output | 12 | Active mode word |
| func_cfg | output | 12 | Active function word |
| cram_valid | output | 1 | Coefficient write valid |
| cram_ready | input | 1 | Coefficient write accepted by consumer |
| cram_addr | output | 7 | Coefficient write address |
| cram_data | output | 18 | Coefficient write data |
| cram_overrun | output | 1 | Sticky flag: a write command was dropped |

## Verification
The bench builds the block with its default parameters: a 26-bit frame, a 7-bit minimum command and two synchroniser stages. These values let it cover both length limits: the shortest key command, the full-length memory write, a 29-bit burst whose first three bits must vanish, and a 6-bit burst that must be rejected.

A held-low `cram_ready` exercises the back-pressure path. Two memory commands inside one period exercise the overrun drop. The deferral rule is observed by reading outputs both before and after each `period_start` pulse.

// File: rtl/hcp_pkg.sv
package hcp_pkg;
  localparam int FRAME_W   = 26;
  localparam int MIN_BITS  = 7;
  localparam int KEY_W     = 4;
  localparam int ATT_W     = 14;
  localparam int CFG_W     = 12;
  localparam int RADDR_W   = 7;
  localparam int RDATA_W   = 18;
  localparam int CENTS_W   = 12;
  localparam int KEY_LSB   = 19;
  localparam int ATT_LSB   = 10;
  localparam int CFG_LSB   = 10;
  localparam int RADDR_LSB = RDATA_W;
  localparam logic [ATT_W-1:0] ATT_RESET = '1;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_KEY, CMD_MODE, CMD_FUNC, CMD_ATT, CMD_RAM
  } cmd_kind_t;

  function automatic logic signed [CENTS_W-1:0] key_to_cents(input logic [KEY_W-1:0] code);
    logic signed [CENTS_W-1:0] step;
    step = signed'({{(CENTS_W-3){1'b0}}, code[2:0]});
    if (!code[3]) key_to_cents = (code[2:0] == 3'd7) ? 12'sd1200 : step * 12'sd100;
    else          key_to_cents = (code[2:0] == 3'd7) ? -12'sd1200 : -(step * 12'sd100);
  endfunction
endpackage

// File: rtl/hcp_sync.sv
module hcp_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] level,
  output logic [N-1:0] rise
);
  logic [N-1:0] stg [STAGES];
  logic [N-1:0] prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stg[g] <= '0;
      else if (g == 0) stg[g] <= async_in;
      else             stg[g] <= stg[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= stg[STAGES-1];
  end

  assign level = stg[STAGES-1];
  assign rise  = stg[STAGES-1] & ~prev;
endmodule

// File: rtl/hcp_shifter.sv
module hcp_shifter #(
  parameter int FRAME_W  = 26,
  parameter int MIN_BITS = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_in,
  input  logic               shift_pulse,
  input  logic               latch_pulse,
  output logic               cmd_valid,
  output logic [FRAME_W-1:0] cmd_frame
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame     <= '0;
      cnt       <= '0;
      cmd_valid <= 1'b0;
      cmd_frame <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (latch_pulse) begin
        cmd_valid <= (cnt >= CNT_W'(MIN_BITS));
        cmd_frame <= frame;
        frame     <= '0;
        cnt       <= '0;
      end else if (shift_pulse) begin
        frame <= {bit_in, frame[FRAME_W-1:1]};
        if (cnt != CNT_W'(FRAME_W)) cnt <= cnt + 1'b1;
      end
    end
  end

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_W));
  // R2
  short_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_pulse && cnt < CNT_W'(MIN_BITS)) |=> !cmd_valid);
endmodule

// File: rtl/hcp_decode.sv
module hcp_decode
  import hcp_pkg::*;
(
  input  logic               cmd_valid,
  input  logic [FRAME_W-1:0] cmd_frame,
  output cmd_kind_t          kind
);
  localparam int TOP = FRAME_W - 1;

  always_comb begin
    kind = CMD_NONE;
    if (cmd_valid) begin
      if (cmd_frame[TOP])          kind = CMD_RAM;
      else if (cmd_frame[TOP-1])   kind = CMD_ATT;
      else if (cmd_frame[TOP-2])   kind = cmd_frame[TOP-3] ? CMD_FUNC : CMD_MODE;
      else                         kind = CMD_KEY;
    end
  end
endmodule

// File: rtl/hcp_regbank.sv
module hcp_regbank
  import hcp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  cmd_kind_t          kind,
  input  logic [FRAME_W-1:0] frame,
  input  logic               period_start,
  input  logic               cram_ready,
  output logic [KEY_W-1:0]   key_code,
  output logic [ATT_W-1:0]   att_level,
  output logic [CFG_W-1:0]   mode_cfg,
  output logic [CFG_W-1:0]   func_cfg,
  output logic               cram_valid,
  output logic [RADDR_W-1:0] cram_addr,
  output logic [RDATA_W-1:0] cram_data,
  output logic               cram_overrun
);
  logic [KEY_W-1:0]   sh_key;
  logic [ATT_W-1:0]   sh_att;
  logic [CFG_W-1:0]   sh_mode, sh_func;
  logic               pend_v;
  logic [RADDR_W-1:0] pend_addr;
  logic [RDATA_W-1:0] pend_data;
  logic               move;

  assign move = period_start && pend_v && !cram_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_key <= '0; sh_att <= ATT_RESET; sh_mode <= '0; sh_func <= '0;
      key_code <= '0; att_level <= ATT_RESET; mode_cfg <= '0; func_cfg <= '0;
      pend_v <= 1'b0; pend_addr <= '0; pend_data <= '0;
      cram_valid <= 1'b0; cram_addr <= '0; cram_data <= '0;
      cram_overrun <= 1'b0;
    end else begin
      if (period_start) begin
        key_code  <= sh_key;
        att_level <= sh_att;
        mode_cfg  <= sh_mode;
        func_cfg  <= sh_func;
      end
      if (cram_valid && cram_ready) cram_valid <= 1'b0;
      if (move) begin
        cram_valid <= 1'b1;
        cram_addr  <= pend_addr;
        cram_data  <= pend_data;
        pend_v     <= 1'b0;
      end
      unique case (kind)
        CMD_KEY:  sh_key  <= frame[KEY_LSB +: KEY_W];
        CMD_ATT:  sh_att  <= frame[ATT_LSB +: ATT_W];
        CMD_MODE: sh_mode <= frame[CFG_LSB +: CFG_W];
        CMD_FUNC: sh_func <= frame[CFG_LSB +: CFG_W];
        CMD_RAM: begin
          if (pend_v && !move) cram_overrun <= 1'b1;
          else begin
            pend_v    <= 1'b1;
            pend_addr <= frame[RADDR_LSB +: RADDR_W];
            pend_data <= frame[0 +: RDATA_W];
          end
        end
        default: ;
      endcase
    end
  end

  // R7
  defer_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(period_start) |-> ($stable(mode_cfg) && $stable(att_level) && $stable(key_code)));
  // R8
  hold_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cram_valid && !cram_ready) |=> (cram_valid && $stable(cram_addr) && $stable(cram_data)));
  // R9
  one_per_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cram_valid) |-> $past(period_start));
  // R9
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cram_overrun) |-> $past(pend_v));
endmodule

// File: rtl/host_cmd_port.sv
module host_cmd_port
  import hcp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ser_data,
  input  logic                      ser_clk,
  input  logic                      ser_latch,
  input  logic                      period_start,
  output logic [KEY_W-1:0]          key_code,
  output logic signed [CENTS_W-1:0] key_cents,
  output logic [ATT_W-1:0]          att_level,
  output logic [CFG_W-1:0]          mode_cfg,
  output logic [CFG_W-1:0]          func_cfg,
  output logic                      cram_valid,
  input  logic                      cram_ready,
  output logic [RADDR_W-1:0]        cram_addr,
  output logic [RDATA_W-1:0]        cram_data,
  output logic                      cram_overrun
);
  logic [2:0]         s_level, s_rise;
  logic               cmd_valid;
  logic [FRAME_W-1:0] cmd_frame;
  cmd_kind_t          kind;

  hcp_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({ser_latch, ser_clk, ser_data}),
    .level(s_level), .rise(s_rise));

  hcp_shifter #(.FRAME_W(FRAME_W), .MIN_BITS(MIN_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .bit_in(s_level[0]), .shift_pulse(s_rise[1]), .latch_pulse(s_rise[2]),
    .cmd_valid(cmd_valid), .cmd_frame(cmd_frame));

  hcp_decode u_dec (.cmd_valid(cmd_valid), .cmd_frame(cmd_frame), .kind(kind));

  hcp_regbank u_regs (
    .clk(clk), .rst_n(rst_n), .kind(kind), .frame(cmd_frame),
    .period_start(period_start), .cram_ready(cram_ready),
    .key_code(key_code), .att_level(att_level), .mode_cfg(mode_cfg), .func_cfg(func_cfg),
    .cram_valid(cram_valid), .cram_addr(cram_addr), .cram_data(cram_data),
    .cram_overrun(cram_overrun));

  assign key_cents = key_to_cents(key_code);

  // R10
  reset_state_chk: assert property (@(posedge clk) !rst_n |=> (!cram_valid && !cram_overrun));
endmodule

// File: tb/sim_host_cmd_port.sv
module sim_host_cmd_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_data = 1'b0, ser_clk = 1'b0, ser_latch = 1'b0, period_start = 1'b0, cram_ready = 1'b1;
  logic [3:0] key_code;
  logic signed [11:0] key_cents;
  logic [13:0] att_level;
  logic [11:0] mode_cfg, func_cfg;
  logic cram_valid, cram_overrun;
  logic [6:0] cram_addr;
  logic [17:0] cram_data;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [24:0] exp_q [$];

  always #2 clk = ~clk;

  host_cmd_port u0 (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) ser_data = b;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Sends `pre` junk ones, then frame bits [26-n .. 25], then latches.
  task automatic send_cmd(input logic [25:0] frame, input int n, input int pre);
    for (int i = 0; i < pre; i++) send_bit(1'b1);
    for (int i = 26 - n; i < 26; i++) send_bit(frame[i]);
    @(negedge clk) ser_latch = 1'b1;
    repeat (4) @(negedge clk);
    ser_latch = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) period_start = 1'b1;
    @(negedge clk) period_start = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic ram_cmd(input logic [6:0] a, input logic [17:0] d, input int pre, input bit expect_out);
    if (expect_out) exp_q.push_back({a, d});
    send_cmd({1'b1, a, d}, 26, pre);
  endtask

  task automatic key_case(input logic [3:0] code, input int cents);
    send_cmd({3'b000, code, 19'd0}, 7, 0);
    tick();
    chk("R3 key_code", key_code, code);
    chk("R3 key_cents", longint'(key_cents), cents);
  endtask

  // Monitor: pops the expected queue on every completed handshake.
  always @(negedge clk) begin
    if (rst_n && cram_valid && cram_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R8 actual=%0h expected=none (unexpected write)", {cram_addr, cram_data});
      end else begin
        logic [24:0] e;
        e = exp_q.pop_front();
        if ({cram_addr, cram_data} != e) begin
          fails++;
          $display("FAIL R8 actual=%0h expected=%0h", {cram_addr, cram_data}, e);
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset values
    chk("R10 mode", mode_cfg, 0);
    chk("R10 func", func_cfg, 0);
    chk("R10 key", key_code, 0);
    chk("R10 att", att_level, 14'h3FFF);
    chk("R10 valid", cram_valid, 0);
    chk("R10 overrun", cram_overrun, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 key mapping
    key_case(4'b0111, 1200);
    key_case(4'b0011, 300);
    key_case(4'b0110, 600);
    key_case(4'b1000, 0);
    key_case(4'b1001, -100);
    key_case(4'b1110, -600);
    key_case(4'b1111, -1200);
    key_case(4'b0000, 0);

    // R4 + R7: attenuator deferred to period start
    send_cmd({2'b01, 14'h1234, 10'd0}, 16, 0);
    chk("R7 att before tick", att_level, 14'h3FFF);
    tick();
    chk("R4 att", att_level, 14'h1234);

    // R5 mode, R6 function
    send_cmd({4'b0010, 12'hA5C, 10'd0}, 16, 0);
    send_cmd({4'b0011, 12'h3C7, 10'd0}, 16, 0);
    chk("R7 mode before tick", mode_cfg, 0);
    tick();
    chk("R5 mode", mode_cfg, 12'hA5C);
    chk("R6 func", func_cfg, 12'h3C7);
    chk("R6 mode untouched", mode_cfg, 12'hA5C);

    // R8 memory write, plain
    ram_cmd(7'h55, 18'h2ABCD, 0, 1'b1);
    chk("R8 no write before tick", cram_valid, 0);
    tick();
    chk("R8 queue drained", exp_q.size(), 0);

    // R1 extra leading bits are dropped
    ram_cmd(7'h0A, 18'h01234, 3, 1'b1);
    tick();
    chk("R1 queue drained", exp_q.size(), 0);

    // R2 short burst of 6 ones ignored
    send_cmd(26'h3FFFFFF, 6, 0);
    tick();
    chk("R2 no write", cram_valid, 0);
    chk("R2 att unchanged", att_level, 14'h1234);
    chk("R2 key unchanged", key_code, 0);

    // R8 back-pressure
    cram_ready = 1'b0;
    ram_cmd(7'h7F, 18'h3FFFF, 0, 1'b1);
    tick();
    repeat (10) @(negedge clk);
    chk("R8 valid held", cram_valid, 1);
    chk("R8 addr held", cram_addr, 7'h7F);
    chk("R8 data held", cram_data, 18'h3FFFF);
    cram_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 valid dropped", cram_valid, 0);

    // R9 overrun: second command dropped
    chk("R9 overrun clear", cram_overrun, 0);
    ram_cmd(7'h11, 18'h00111, 0, 1'b1);
    ram_cmd(7'h22, 18'h00222, 0, 1'b0);
    chk("R9 overrun set", cram_overrun, 1);
    tick();
    tick();
    chk("R9 only one written", exp_q.size(), 0);
    chk("R9 overrun sticky", cram_overrun, 1);

    repeat (5) @(negedge clk);
    chk("R8 queue empty at end", exp_q.size(), 0);
    finish_run();
  end
endmodule